// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance-counter slice. In every clock cycle it receives a bank of event lines, arranged as groups of eight sub-event lines with one group per event code. It also receives the current two-bit privilege ring. A configuration word selects one group and picks lines inside it with a mask. The selected lines that are active in a cycle are added up. That sum is then either added directly to the counter or turned into a yes/no condition by comparing it with a threshold. The condition can be inverted, reduced to its rising edges, and gated by privilege ring before it reaches the counter.

Software reaches the slice through a small register port. Address 0 holds the configuration word, address 1 holds the counter value and address 2 holds the overflow status. Writes take one cycle. Reads are combinational. When the counter wraps past its top value it sets a sticky status bit, and while interrupts are enabled that bit drives an interrupt line. Chaining into a neighbouring slice is not supported.

Top module: `qual_event_counter`

## Requirements
- R1: After reset the counter, the configuration word and the overflow status all read as zero, and `irq` is low.
- R2: Configuration bits [7:0] select the event group. Group k is `eventLines[8k+7:8k]`, and a selector of `NUM_CODES` or higher selects no events. Mask bits [15:8] enable sub-line i of the group through mask bit i. The per-cycle count is the number of enabled sub-lines that are high.
- R3: When the threshold field [23:16] is zero and edge mode is off, the counter adds the full per-cycle count, and the invert bit [24] has no effect.
- R4: When the threshold is nonzero and invert is clear, the counter adds one in each cycle whose count is greater than or equal to the threshold.
- R5: When the threshold is nonzero and invert is set, the counter adds one in each cycle whose count is strictly below the threshold.
- R6: With edge mode [25] set, the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. With a zero threshold, the condition is "count nonzero".
- R7: With the ring-0 enable [26] set, events count only while `cpl` is 0. With the outer-ring enable [27] set, they count only while `cpl` is 1, 2 or 3. With both clear, every ring counts.
- R8: With the enable bit [29] clear, the counter holds its value whatever the events are.
- R9: A write to address 1 loads the counter, and it overrides any increment in the same cycle.
- R10: A carry out of the top counter bit sets status bit 0, which reads at address 2 and stays set until a write to address 2 with data bit 0 set clears it. `irq` equals that status bit ANDed with the interrupt enable [28].
- R11: The edge history is cleared by any configuration write and while the counter is disabled. A condition that stays true therefore counts again after either of these.
- R12: The configuration word written at address 0 reads back unchanged in bits [29:0], and the upper read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eventLines | input | NUM_CODES*8 | Per-cycle event lines, eight per event code |
| cpl | input | 2 | Current privilege ring |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 config, 1 counter, 2 status |
| wrData | input | CNT_W | Write data |
| rdAddr | input | 2 | Read address, same map as writes |
| rdData | output | CNT_W | Combinational read data |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions assume that `rstN` is held low through at least one edge and that every input is stable around the active clock edge. They also assume that the configuration changes only through a write to address 0, and that address 3 is never used for a meaningful write. The stimulus changes inputs only shortly after a rising edge and keeps `wrAddr` within 0 to 2. Status clears are issued only after the wrap that set the bit, so a set and a clear never land in the same cycle.

// File: rtl/qec_pkg.sv
package qec_pkg;
  localparam int SUB_W = 8;
  localparam int AMT_W = $clog2(SUB_W + 1);
  localparam int CFG_W = 30;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic       enable;    // 29
    logic       intEn;     // 28
    logic       usrEn;     // 27
    logic       osEn;      // 26
    logic       edgeMode;  // 25
    logic       invert;    // 24
    logic [7:0] thresh;    // 23:16
    logic [7:0] umask;     // 15:8
    logic [7:0] evtSel;    // 7:0
  } cfg_t;

  typedef struct packed {
    logic             load;
    logic             clrOvf;
    logic [AMT_W-1:0] incAmt;
  } strobe_t;
endpackage

// File: rtl/qec_ctrl.sv
module qec_ctrl
  import qec_pkg::*;
#(
  parameter int NUM_CODES = 4,
  parameter int CNT_W     = 48
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CODES*SUB_W-1:0] eventLines,
  input  logic [1:0]             cpl,
  input  logic                   wrEn,
  input  logic [1:0]             wrAddr,
  input  logic [CNT_W-1:0]       wrData,
  output cfg_t                   cfg,
  output strobe_t                strb
);
  logic [SUB_W-1:0] selLines, masked;
  logic [AMT_W-1:0] evtCount;
  logic privOk, cond, qualified, prevQual, cfgWr, bothOff;

  assign cfgWr = wrEn && (wrAddr == ADDR_CFG);

  // Event group selection and per-cycle summation
  always_comb begin
    selLines = '0;
    for (int c = 0; c < NUM_CODES; c++)
      if (32'(cfg.evtSel) == c) selLines = eventLines[c*SUB_W +: SUB_W];
  end

  assign masked = selLines & cfg.umask;

  always_comb begin
    evtCount = '0;
    for (int i = 0; i < SUB_W; i++) evtCount = evtCount + AMT_W'(masked[i]);
  end

  // Privilege ring filter
  assign bothOff = !cfg.osEn && !cfg.usrEn;
  assign privOk  = (cpl == 2'd0) ? (cfg.osEn || bothOff) : (cfg.usrEn || bothOff);

  // Threshold compare with optional inversion
  always_comb begin
    if (cfg.thresh != 8'd0)
      cond = cfg.invert ? (8'(evtCount) < cfg.thresh) : (8'(evtCount) >= cfg.thresh);
    else
      cond = (evtCount != '0);
  end

  assign qualified = cfg.enable && privOk && cond;

  always_comb begin
    strb.load   = wrEn && (wrAddr == ADDR_CNT);
    strb.clrOvf = wrEn && (wrAddr == ADDR_STAT) && wrData[0];
    if (cfg.edgeMode)
      strb.incAmt = (qualified && !prevQual) ? AMT_W'(1) : '0;
    else if (cfg.thresh == 8'd0)
      strb.incAmt = qualified ? evtCount : '0;
    else
      strb.incAmt = qualified ? AMT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= '0;
      prevQual <= 1'b0;
    end else begin
      if (cfgWr) cfg <= cfg_t'(wrData[CFG_W-1:0]);
      if (cfgWr || !cfg.enable) prevQual <= 1'b0;
      else                      prevQual <= qualified;
    end
  end

  // R6: an edge-mode increment cannot repeat in the next cycle without a config write
  p_edge_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.edgeMode && strb.incAmt != '0 && !cfgWr) |=> (strb.incAmt == '0));

  // R4: a nonzero threshold never adds more than one per cycle
  p_thresh_unit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.thresh != 8'd0) |-> (strb.incAmt <= AMT_W'(1)));

  // R8: a disabled slice issues no increment
  p_disabled_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |-> (strb.incAmt == '0));

  // R11: a config write re-arms edge mode for a condition that stays true
  p_edge_rearm_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfg_t'(wrData[CFG_W-1:0]) == cfg && cfg.edgeMode && qualified)
      |=> (qualified |-> strb.incAmt == AMT_W'(1)));
endmodule

// File: rtl/qec_datapath.sv
module qec_datapath
  import qec_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic             intEn,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             irq
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt} + (CNT_W+1)'(strb.incAmt);
  assign irq = ovf && intEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (strb.load) cnt <= wrData;
      else           cnt <= sum[CNT_W-1:0];
      if (!strb.load && sum[CNT_W]) ovf <= 1'b1;
      else if (strb.clrOvf)         ovf <= 1'b0;
    end
  end

  // R9: a counter write lands exactly, whatever the increment
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (cnt == $past(wrData)));

  // R10: status stays set until cleared
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !strb.clrOvf) |=> ovf);

  // R10: no interrupt without status
  p_irq_status_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ovf);
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
  import qec_pkg::*;
#(
  parameter int NUM_CODES = 4,
  parameter int CNT_W     = 48
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CODES*8-1:0]     eventLines,
  input  logic [1:0]                 cpl,
  input  logic                       wrEn,
  input  logic [1:0]                 wrAddr,
  input  logic [CNT_W-1:0]           wrData,
  input  logic [1:0]                 rdAddr,
  output logic [CNT_W-1:0]           rdData,
  output logic                       irq
);
  cfg_t             cfg;
  strobe_t          strb;
  logic [CNT_W-1:0] cnt;
  logic             ovf;

  qec_ctrl #(.NUM_CODES(NUM_CODES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .eventLines(eventLines), .cpl(cpl),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .cfg(cfg), .strb(strb)
  );

  qec_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .intEn(cfg.intEn), .cnt(cnt), .ovf(ovf), .irq(irq)
  );

  always_comb begin
    case (rdAddr)
      ADDR_CFG:  rdData = CNT_W'(cfg);
      ADDR_CNT:  rdData = cnt;
      ADDR_STAT: rdData = CNT_W'(ovf);
      default:   rdData = '0;
    endcase
  end
endmodule

// File: tb/sim_qual_event_counter.sv
module sim_qual_event_counter;
  localparam int NC = 4;
  localparam int W  = 48;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NC*8-1:0] ev = '0;
  logic [1:0]    cpl = 2'd0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrAddr = 2'd0;
  logic [W-1:0]  wrData = '0;
  logic [1:0]    rdAddr = 2'd1;
  logic [W-1:0]  rdData;
  logic          irq;

  int nChecks = 0, nFails = 0;
  string curReq = "R1";

  // reference model state
  logic [29:0]  mCfg = '0;
  logic [W-1:0] mCnt = '0;
  bit           mOvf = 0, mPrev = 0;

  always #2 clk = ~clk;

  qual_event_counter #(.NUM_CODES(NC), .CNT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .eventLines(ev), .cpl(cpl), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  function automatic logic [29:0] mk(bit en, bit ie, bit usr, bit os, bit edg,
                                     bit inv, int thr, int um, int sel);
    return {en, ie, usr, os, edg, inv, 8'(thr), 8'(um), 8'(sel)};
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int n, sel, thr, inc;
    bit cond, priv, qual;
    logic [W:0] s;
    sel = int'(mCfg[7:0]);
    thr = int'(mCfg[23:16]);
    n = 0;
    if (sel < NC)
      for (int i = 0; i < 8; i++) if (ev[sel*8+i] && mCfg[8+i]) n++;
    if (!mCfg[26] && !mCfg[27]) priv = 1;
    else priv = (cpl == 0) ? mCfg[26] : mCfg[27];
    if (thr == 0) cond = (n > 0);
    else if (mCfg[24]) cond = (n < thr);
    else cond = (n >= thr);
    qual = mCfg[29] && priv && cond;
    if (mCfg[25]) inc = (qual && !mPrev) ? 1 : 0;
    else if (thr == 0) inc = qual ? n : 0;
    else inc = qual ? 1 : 0;
    s = {1'b0, mCnt} + (W+1)'(inc);
    if (wrEn && wrAddr == 1) mCnt = wrData;
    else begin
      mCnt = s[W-1:0];
      if (s[W]) mOvf = 1;
    end
    if (wrEn && wrAddr == 2 && wrData[0] && !(s[W] && !(wrAddr == 1))) mOvf = 0;
    mPrev = (wrEn && wrAddr == 0) || !mCfg[29] ? 0 : qual;
    if (wrEn && wrAddr == 0) mCfg = wrData[29:0];
  endtask

  task automatic step();
    model_step();
    @(posedge clk); #1;
    check(curReq, rdData, mCnt);
    check({curReq, "/irq"}, W'(irq), W'(mOvf && mCfg[28]));
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    step();
    wrEn = 0;
  endtask

  task automatic peek(logic [1:0] a, logic [W-1:0] exp, string req);
    rdAddr = a; #0.5;
    check(req, rdData, exp);
    rdAddr = 2'd1; #0.5;
  endtask

  task automatic grp(int code, int lines);
    ev = '0;
    ev[code*8 +: 8] = 8'(lines);
  endtask

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    peek(0, '0, "R1"); peek(1, '0, "R1"); peek(2, '0, "R1");
    check("R1/irq", W'(irq), '0);

    // R12 config readback
    curReq = "R12";
    wr(0, W'(mk(0, 1, 1, 0, 1, 0, 8'h5A, 8'hC3, 3)));
    peek(0, W'(mk(0, 1, 1, 0, 1, 0, 8'h5A, 8'hC3, 3)), "R12");

    // R3 full sum, invert ignored
    curReq = "R3";
    wr(0, W'(mk(1, 0, 0, 0, 0, 1, 0, 8'hFF, 1)));
    grp(1, 8'hFF); step();
    grp(1, 8'h11); ev[7:0] = 8'hFF; step();
    grp(1, 8'h00); step();
    grp(1, 8'h7E); step();

    // R2 unit mask and out-of-range selector
    curReq = "R2";
    wr(0, W'(mk(1, 0, 0, 0, 0, 0, 0, 8'h0F, 2)));
    grp(2, 8'hFF); step();
    grp(2, 8'hF0); step();
    grp(2, 8'h05); step();
    wr(0, W'(mk(1, 0, 0, 0, 0, 0, 0, 8'hFF, 7)));
    ev = '1; step(); step();

    // R4 threshold >=
    curReq = "R4";
    wr(0, W'(mk(1, 0, 0, 0, 0, 0, 3, 8'hFF, 0)));
    grp(0, 8'h03); step();
    grp(0, 8'h07); step();
    grp(0, 8'h1F); step();
    grp(0, 8'h00); step();

    // R5 inverted threshold
    curReq = "R5";
    wr(0, W'(mk(1, 0, 0, 0, 0, 1, 3, 8'hFF, 0)));
    grp(0, 8'h03); step();
    grp(0, 8'h07); step();
    grp(0, 8'h00); step();
    grp(0, 8'hFF); step();

    // R6 edge mode
    curReq = "R6";
    wr(0, W'(mk(1, 0, 0, 0, 1, 0, 1, 8'hFF, 3)));
    grp(3, 8'h01); step(); step(); step();
    grp(3, 8'h00); step();
    grp(3, 8'h80); step(); step();

    // R11 history cleared by config write and by disable
    curReq = "R11";
    wr(0, W'(mk(1, 0, 0, 0, 1, 0, 1, 8'hFF, 3)));
    step(); step();
    wr(0, W'(mk(0, 0, 0, 0, 1, 0, 1, 8'hFF, 3)));
    step();
    wr(0, W'(mk(1, 0, 0, 0, 1, 0, 1, 8'hFF, 3)));
    step(); step();

    // R7 privilege filtering
    curReq = "R7";
    wr(0, W'(mk(1, 0, 0, 1, 0, 0, 0, 8'hFF, 1)));
    grp(1, 8'h03);
    for (int r = 0; r < 4; r++) begin cpl = 2'(r); step(); end
    wr(0, W'(mk(1, 0, 1, 0, 0, 0, 0, 8'hFF, 1)));
    for (int r = 0; r < 4; r++) begin cpl = 2'(r); step(); end
    wr(0, W'(mk(1, 0, 0, 0, 0, 0, 0, 8'hFF, 1)));
    for (int r = 0; r < 4; r++) begin cpl = 2'(r); step(); end
    cpl = 0;

    // R8 disabled
    curReq = "R8";
    wr(0, W'(mk(0, 0, 0, 0, 0, 0, 0, 8'hFF, 1)));
    grp(1, 8'hFF); step(); step(); step();

    // R9 counter write wins over increment
    curReq = "R9";
    wr(0, W'(mk(1, 0, 0, 0, 0, 0, 0, 8'hFF, 1)));
    wr(1, 48'h0000_1234_5678);
    step();

    // R10 overflow, sticky status, interrupt, clear
    curReq = "R10";
    grp(1, 8'h0F);
    wr(0, W'(mk(1, 1, 0, 0, 0, 0, 0, 8'hFF, 1)));
    wr(1, {W{1'b1}} - W'(6));
    step(); step();
    ev = '0; step();
    peek(2, W'(1), "R10");
    step();
    wr(2, W'(1));
    peek(2, '0, "R10");
    grp(1, 8'h0F);
    wr(0, W'(mk(1, 0, 0, 0, 0, 0, 0, 8'hFF, 1)));
    wr(1, {W{1'b1}});
    step();
    peek(2, W'(1), "R10");
    check("R10/irq-masked", W'(irq), '0);
    ev = '0;
    wr(2, W'(1)); step();

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule